// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block orders a clock generator's move into and out of its low-power state. An active-low power-down pin arrives with no timing relation to the core, so it passes through a synchronizer before anything acts on it. A request first parks every clock output low. On the CPU-clock side the park takes effect on the falling edge that follows the state change. On the reference-clock side the park is confirmed through a handshake that crosses both ways between the domains. Only when both sides are parked do the PLL enables drop, and after that the oscillator enable.

When the pin is released, the oscillator restarts and a settle interval runs. The PLLs are then enabled, and the block waits for their lock indication or for a timeout counter, whichever comes first. A short release interval follows before the outputs run again. While the block is powering down, a separate CPU-clock stop input has no effect, because the power-down park already holds the CPU clocks low. Outside power-down, that input stops only the CPU clocks. The analog parts appear only as enable outputs and a lock input.

Top module: `pwrdn_seq`

## Requirements
- R1: Under reset, `seq_state_o` reads RUN (0), all three park outputs are low, and both `pll_en_o` and `osc_en_o` are high.
- R2: When the pin is held low, the sequencer leaves RUN only toward FREEZE (1), once the synchronized request is present and no earlier reference-side park is still acknowledged. `clk_park_o` is high on every falling edge where the state is not RUN and low where it is RUN.
- R3: FREEZE ends only after the reference-domain park has been acknowledged. Whenever the PLLs are disabled, `clk_park_o` and `ref_park_o` are both high.
- R4: PLL_OFF (2) lasts exactly one cycle and is followed by OSC_OFF (3). `osc_en_o` is low only in OSC_OFF, and it never falls while the PLLs are enabled.
- R5: OSC_START (4) keeps the oscillator on and the PLLs off for OSC_SETTLE_CYC+1 cycles. `pll_en_o` is high only in RUN, FREEZE, PLL_WAIT and RELEASE.
- R6: PLL_WAIT (5) moves to RELEASE after LOCK_TIMEOUT_CYC+1 cycles when no lock is seen, or earlier once the synchronized lock input is high.
- R7: RELEASE (6) keeps the outputs parked for RELEASE_CYC+1 cycles, then returns to RUN, and the park drops on the next falling edge.
- R8: OSC_OFF holds while the request persists. A pin released part-way through shutdown still completes through OSC_OFF and then restarts, and that OSC_OFF lasts one cycle. A request present at the end of a wake leads back into FREEZE.
- R9: In RUN, a synchronized low on `cpu_stop_pin_n` raises `cpu_park_o` without changing state. Outside RUN, `cpu_park_o` stays high whatever that input does.
- R10: Elaboration rejects a configuration whose worst wake path (oscillator settle + lock timeout + release + synchronizer latency) exceeds WAKE_BUDGET_CYC. The three wake states together never run longer than OSC_SETTLE_CYC+LOCK_TIMEOUT_CYC+RELEASE_CYC+3 cycles.
- R11: `seq_state_o` uses the codes RUN=0, FREEZE=1, PLL_OFF=2, OSC_OFF=3, OSC_START=4, PLL_WAIT=5, RELEASE=6. The code 7 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Internal CPU clock; all sequencing refers to it |
| ref_clk | input | 1 | Reference-output clock domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_pin_n | input | 1 | Asynchronous active-low power-down request |
| cpu_stop_pin_n | input | 1 | Asynchronous active-low CPU-clock stop request |
| pll_locked | input | 1 | Lock indication from the PLLs |
| clk_park_o | output | 1 | Holds all CPU-domain clock outputs low |
| ref_park_o | output | 1 | Holds reference and fixed-frequency outputs low |
| cpu_park_o | output | 1 | Holds the CPU clock outputs low |
| pll_en_o | output | 1 | PLL (VCO) enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| seq_state_o | output | 3 | Current sequencer state code |

## Verification
Two requests can land in the same cycle: a power-down request and a CPU-clock stop request. The bench lowers both pins in the same statement and holds the stop low through a full shutdown, a wake and a second power-down that starts before the first wake has finished. The CPU park must stay high in every non-RUN cycle, and the stop alone must keep it high once RUN returns. A scoreboard compares each state the block enters, and the time spent in each timed state, against the expected sequence.

// File: rtl/pds_pkg.sv
package pds_pkg;

   localparam int SEQ_W = 3;

   typedef enum logic [SEQ_W-1:0] {
      SEQ_RUN       = 3'd0,
      SEQ_FREEZE    = 3'd1,
      SEQ_PLL_OFF   = 3'd2,
      SEQ_OSC_OFF   = 3'd3,
      SEQ_OSC_START = 3'd4,
      SEQ_PLL_WAIT  = 3'd5,
      SEQ_RELEASE   = 3'd6
   } seq_state_e;

   // PLLs run in every state except the three around the oscillator being off
   function automatic logic pll_on(seq_state_e s);
      return (s == SEQ_RUN) || (s == SEQ_FREEZE) ||
             (s == SEQ_PLL_WAIT) || (s == SEQ_RELEASE);
   endfunction

endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pds_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic             expired
);

   if (WIDTH < 1) begin : g_bad_width
      $error("pds_timer: WIDTH must be positive");
   end

   logic [WIDTH-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // An idle counter must not wrap around into a new interval
   AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt) == '0 && !$past(load)) |-> (cnt == '0)); // R5

endmodule

// File: rtl/pds_ref_park.sv
module pds_ref_park #(
   parameter int STAGES = 2
) (
   input  logic ref_clk,
   input  logic cpu_clk,
   input  logic rst_n,
   input  logic park_req,
   output logic ref_park_o,
   output logic park_ack
);

   // forward leg: CPU-domain park into the reference domain
   pds_sync #(.STAGES(STAGES), .RESET_VAL(1'b0)) u_fwd (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (park_req),
      .q     (ref_park_o)
   );

   // return leg: confirmation that the reference outputs are parked
   pds_sync #(.STAGES(STAGES), .RESET_VAL(1'b0)) u_back (
      .clk   (cpu_clk),
      .rst_n (rst_n),
      .d     (ref_park_o),
      .q     (park_ack)
   );

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
   import pds_pkg::*;
#(
   parameter int TMR_W     = 8,
   parameter int OSC_LOAD  = 10,
   parameter int LOCK_LOAD = 40,
   parameter int REL_LOAD  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_req,
   input  logic             ref_ack,
   input  logic             lock_ok,
   input  logic             tmr_expired,
   output seq_state_e       state,
   output logic             tmr_load,
   output logic [TMR_W-1:0] tmr_val
);

   localparam logic [TMR_W-1:0] OSC_V  = TMR_W'(OSC_LOAD);
   localparam logic [TMR_W-1:0] LOCK_V = TMR_W'(LOCK_LOAD);
   localparam logic [TMR_W-1:0] REL_V  = TMR_W'(REL_LOAD);

   seq_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         SEQ_RUN:       if (pd_req && !ref_ack)       nxt = SEQ_FREEZE;
         SEQ_FREEZE:    if (ref_ack)                  nxt = SEQ_PLL_OFF;
         SEQ_PLL_OFF:                                 nxt = SEQ_OSC_OFF;
         SEQ_OSC_OFF:   if (!pd_req)                  nxt = SEQ_OSC_START;
         SEQ_OSC_START: if (tmr_expired)              nxt = SEQ_PLL_WAIT;
         SEQ_PLL_WAIT:  if (lock_ok || tmr_expired)   nxt = SEQ_RELEASE;
         SEQ_RELEASE:   if (tmr_expired)              nxt = SEQ_RUN;
         default:                                     nxt = SEQ_RUN;
      endcase
   end

   // each timed state gets its interval loaded on entry
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (nxt != state) begin
         unique case (nxt)
            SEQ_OSC_START: begin tmr_load = 1'b1; tmr_val = OSC_V;  end
            SEQ_PLL_WAIT:  begin tmr_load = 1'b1; tmr_val = LOCK_V; end
            SEQ_RELEASE:   begin tmr_load = 1'b1; tmr_val = REL_V;  end
            default:       begin tmr_load = 1'b0; tmr_val = '0;     end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEQ_RUN;
      else        state <= nxt;
   end

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state != seq_state_e'(3'd7))); // R11

   AST_PLL_OFF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_PLL_OFF) |=> (state == SEQ_OSC_OFF)); // R4

   AST_OFF_HOLDS_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_OSC_OFF && pd_req) |=> (state == SEQ_OSC_OFF)); // R8

   AST_RUN_EXITS_TO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_RUN) |=> (state == SEQ_RUN || state == SEQ_FREEZE)); // R2

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
   import pds_pkg::*;
#(
   parameter int SYNC_STAGES      = 2,
   parameter int OSC_SETTLE_CYC   = 4000,
   parameter int LOCK_TIMEOUT_CYC = 30000,
   parameter int RELEASE_CYC      = 16,
   parameter int WAKE_BUDGET_CYC  = 400000,
   parameter bit LOCK_WAIT        = 1'b1
) (
   input  logic             cpu_clk,
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             pwrdn_pin_n,
   input  logic             cpu_stop_pin_n,
   input  logic             pll_locked,
   output logic             clk_park_o,
   output logic             ref_park_o,
   output logic             cpu_park_o,
   output logic             pll_en_o,
   output logic             osc_en_o,
   output logic [SEQ_W-1:0] seq_state_o
);

   localparam int MAX_A      = (OSC_SETTLE_CYC > LOCK_TIMEOUT_CYC) ? OSC_SETTLE_CYC : LOCK_TIMEOUT_CYC;
   localparam int MAX_LOAD   = (MAX_A > RELEASE_CYC) ? MAX_A : RELEASE_CYC;
   localparam int TMR_W      = $clog2(MAX_LOAD + 1);
   localparam int WAKE_WORST = OSC_SETTLE_CYC + LOCK_TIMEOUT_CYC + RELEASE_CYC + 3;
   localparam int WAKE_TOTAL = WAKE_WORST + SYNC_STAGES + 1;
   localparam int WAKE_W     = $clog2(WAKE_WORST + 2);

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("pwrdn_seq: SYNC_STAGES must be at least 2");
   end
   if (OSC_SETTLE_CYC < 1 || LOCK_TIMEOUT_CYC < 1 || RELEASE_CYC < 1) begin : g_chk_intervals
      $error("pwrdn_seq: every wake interval must be at least one cycle");
   end
   if (WAKE_TOTAL > WAKE_BUDGET_CYC) begin : g_chk_budget // R10
      $error("pwrdn_seq: worst-case wake path exceeds WAKE_BUDGET_CYC");
   end

   logic             pd_sync_q;
   logic             stop_sync_q;
   logic             lock_ok;
   logic             ref_ack;
   logic             tmr_load;
   logic             tmr_expired;
   logic [TMR_W-1:0] tmr_val;
   seq_state_e       state;
   logic             pd_req;
   logic             stop_req;

   pds_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pd_sync (
      .clk (cpu_clk), .rst_n (rst_n), .d (pwrdn_pin_n), .q (pd_sync_q)
   );

   pds_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_stop_sync (
      .clk (cpu_clk), .rst_n (rst_n), .d (cpu_stop_pin_n), .q (stop_sync_q)
   );

   // variant: wait for lock or timeout, or for the timeout alone
   if (LOCK_WAIT) begin : g_lock
      pds_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_lock_sync (
         .clk (cpu_clk), .rst_n (rst_n), .d (pll_locked), .q (lock_ok)
      );
   end else begin : g_timeout_only
      assign lock_ok = 1'b0;
   end

   assign pd_req   = ~pd_sync_q;
   assign stop_req = ~stop_sync_q;

   pds_fsm #(
      .TMR_W     (TMR_W),
      .OSC_LOAD  (OSC_SETTLE_CYC),
      .LOCK_LOAD (LOCK_TIMEOUT_CYC),
      .REL_LOAD  (RELEASE_CYC)
   ) u_fsm (
      .clk         (cpu_clk),
      .rst_n       (rst_n),
      .pd_req      (pd_req),
      .ref_ack     (ref_ack),
      .lock_ok     (lock_ok),
      .tmr_expired (tmr_expired),
      .state       (state),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val)
   );

   pds_timer #(.WIDTH(TMR_W)) u_timer (
      .clk      (cpu_clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   // outputs are parked on the falling edge that follows the state change
   always_ff @(negedge cpu_clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_park_o <= 1'b0;
         cpu_park_o <= 1'b0;
      end else begin
         clk_park_o <= (state != SEQ_RUN);
         cpu_park_o <= (state != SEQ_RUN) | stop_req;
      end
   end

   pds_ref_park #(.STAGES(SYNC_STAGES)) u_ref_park (
      .ref_clk    (ref_clk),
      .cpu_clk    (cpu_clk),
      .rst_n      (rst_n),
      .park_req   (clk_park_o),
      .ref_park_o (ref_park_o),
      .park_ack   (ref_ack)
   );

   assign pll_en_o    = pll_on(state);
   assign osc_en_o    = (state != SEQ_OSC_OFF);
   assign seq_state_o = state;

   // wake-duration counter, used only by the budget assertion
   logic [WAKE_W-1:0] wake_cnt;
   always_ff @(posedge cpu_clk or negedge rst_n) begin
      if (!rst_n) wake_cnt <= '0;
      else if (state == SEQ_OSC_START || state == SEQ_PLL_WAIT || state == SEQ_RELEASE)
         wake_cnt <= (wake_cnt == WAKE_W'(WAKE_WORST + 1)) ? wake_cnt : wake_cnt + 1'b1;
      else
         wake_cnt <= '0;
   end

   AST_WAKE_BUDGET: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (wake_cnt <= WAKE_W'(WAKE_WORST))); // R10

   AST_PARKED_BEFORE_PLL_OFF: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (!pll_en_o) |-> (clk_park_o && ref_park_o)); // R3

   AST_OSC_FALLS_AFTER_PLL: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      $fell(osc_en_o) |-> $past(!pll_en_o)); // R4

   AST_OSC_ON_WITH_PLL: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      pll_en_o |-> osc_en_o); // R4

   AST_CPU_PARK_IN_PD: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (seq_state_o != SEQ_W'(SEQ_RUN)) |-> cpu_park_o); // R9

   AST_PARK_RISES_IN_FREEZE: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      $rose(clk_park_o) |-> (seq_state_o == SEQ_W'(SEQ_FREEZE))); // R2

endmodule

// File: tb/pwrdn_seq_bench.sv
`timescale 1ns/1ps
module pwrdn_seq_bench;

   localparam int OSC_C  = 10;
   localparam int LOCK_C = 40;
   localparam int REL_C  = 5;

   logic       clk = 1'b0;
   logic       ref_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pd_n = 1'b1;
   logic       stop_n = 1'b1;
   logic       pll_locked = 1'b0;
   logic       clk_park, ref_park, cpu_park, pll_en, osc_en;
   logic [2:0] st;

   always #2   clk = ~clk;
   always #3.5 ref_clk = ~ref_clk;

   pwrdn_seq #(
      .SYNC_STAGES(2), .OSC_SETTLE_CYC(OSC_C), .LOCK_TIMEOUT_CYC(LOCK_C),
      .RELEASE_CYC(REL_C), .WAKE_BUDGET_CYC(200), .LOCK_WAIT(1'b1)
   ) u_pwrdn_seq (
      .cpu_clk(clk), .ref_clk(ref_clk), .rst_n(rst_n), .pwrdn_pin_n(pd_n),
      .cpu_stop_pin_n(stop_n), .pll_locked(pll_locked), .clk_park_o(clk_park),
      .ref_park_o(ref_park), .cpu_park_o(cpu_park), .pll_en_o(pll_en),
      .osc_en_o(osc_en), .seq_state_o(st)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // PLL model: lock appears 12 cycles after enable when lock_mode is set
   bit lock_mode = 1'b0;
   int lock_cnt = 0;
   always @(negedge clk) begin
      if (!lock_mode || !pll_en) begin
         lock_cnt = 0;
         pll_locked <= 1'b0;
      end else if (lock_cnt == 12) pll_locked <= 1'b1;
      else lock_cnt++;
   end

   // scoreboard: expected state and dwell (-1 any, -2 earlier than timeout)
   typedef struct { int st; int dw; } exp_t;
   exp_t sb_q[$];

   task automatic push(input int s, input int d);
      exp_t e;
      e.st = s; e.dw = d;
      sb_q.push_back(e);
   endtask

   task automatic push_cycle(input int off_dw, input int wait_dw);
      push(1, -1); push(2, 1); push(3, off_dw); push(4, OSC_C + 1);
      push(5, wait_dw); push(6, REL_C + 1); push(0, -1);
   endtask

   int cyc = 0, enter_cyc = 0, prev_st = 0, cur_st = 0, cur_dw = -1;

   function automatic string dwell_tag(input int s);
      case (s)
         2: return "R4 dwell";
         3: return "R8 dwell";
         4: return "R5 dwell";
         5: return "R6 dwell";
         6: return "R7 dwell";
         default: return "R2 dwell";
      endcase
   endfunction

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         cyc++;
         if (int'(st) != prev_st) begin
            int dw;
            dw = cyc - enter_cyc;
            if (cur_dw == -2) chk(dw >= 2 && dw <= LOCK_C, "R6 early lock exit", dw, LOCK_C);
            else if (cur_dw >= 0) chk(dw == cur_dw, dwell_tag(cur_st), dw, cur_dw);
            if (sb_q.size() == 0) chk(1'b0, "R11 unexpected state", int'(st), prev_st);
            else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(int'(st) == e.st, "R11 state order", int'(st), e.st);
               cur_st = e.st; cur_dw = e.dw;
            end
            enter_cyc = cyc;
            prev_st = int'(st);
         end
         chk(clk_park == (st != 3'd0), "R2/R7 park", clk_park, st != 3'd0);
         chk(osc_en == (st != 3'd3), "R4 osc enable", osc_en, st != 3'd3);
         chk(pll_en == (st == 3'd0 || st == 3'd1 || st == 3'd5 || st == 3'd6),
             "R5 pll enable", pll_en, !pll_en);
         if (st != 3'd0) chk(cpu_park == 1'b1, "R9 cpu park in power-down", cpu_park, 1);
         if (st == 3'd2) chk(ref_park == 1'b1, "R3 ref parked", ref_park, 1);
      end
   end

   task automatic wait_state(input int s);
      while (int'(st) != s) @(negedge clk);
   endtask

   task automatic drain();
      while (sb_q.size() != 0) @(negedge clk);
      wait_state(0);
      repeat (12) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      #1;
      // R1 reset values
      chk(st == 3'd0, "R1 state", st, 0);
      chk(!clk_park && !ref_park && !cpu_park, "R1 parks", {clk_park, ref_park, cpu_park}, 0);
      chk(pll_en && osc_en, "R1 enables", {pll_en, osc_en}, 3);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      #1;
      chk(ref_park == 1'b0, "R1 ref park idle", ref_park, 0);

      // R9 stop alone in RUN
      stop_n = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      chk(cpu_park == 1'b1, "R9 stop parks cpu", cpu_park, 1);
      chk(st == 3'd0 && !clk_park, "R9 stop keeps RUN", st, 0);
      stop_n = 1'b1;
      repeat (5) @(negedge clk);
      #1;
      chk(cpu_park == 1'b0, "R9 stop released", cpu_park, 0);

      // R6 timeout path, R8 hold in OSC_OFF
      lock_mode = 1'b0;
      push_cycle(-1, LOCK_C + 1);
      pd_n = 1'b0;
      wait_state(3);
      repeat (20) @(negedge clk);
      #1;
      chk(st == 3'd3 && !osc_en && !pll_en, "R8 off held", st, 3);
      pd_n = 1'b1;
      drain();

      // R6 lock path
      lock_mode = 1'b1;
      push_cycle(-1, -2);
      pd_n = 1'b0;
      wait_state(3);
      pd_n = 1'b1;
      drain();

      // R8 release during FREEZE still passes OSC_OFF
      push_cycle(1, -2);
      pd_n = 1'b0;
      wait_state(1);
      pd_n = 1'b1;
      drain();

      // stop and power-down together, re-request during wake
      push_cycle(-1, -2);
      push_cycle(-1, -2);
      stop_n = 1'b0;
      pd_n = 1'b0;
      wait_state(3);
      pd_n = 1'b1;
      wait_state(5);
      pd_n = 1'b0;
      wait_state(0);
      wait_state(3);
      pd_n = 1'b1;
      drain();
      #1;
      chk(cpu_park == 1'b1, "R9 stop still honoured in RUN", cpu_park, 1);
      stop_n = 1'b1;
      repeat (5) @(negedge clk);
      #1;
      chk(cpu_park == 1'b0, "R9 stop cleared", cpu_park, 0);
      chk(sb_q.size() == 0, "R11 all states seen", sb_q.size(), 0);
      finish_run();
   end

endmodule